// File: doc/BRIEF.md
# Parallel ATA PIO Register Access Sequencer

This block sits on the host side of a parallel disk bus run in its IDE-compatible mode. It runs one register read or register write at a time against the attached device. A requester supplies a register space (task file or control block), a 3-bit register number, a direction, a word/byte flag and write data. The sequencer then drives the two active-low chip selects, the register address, the read and write strobes and the data bus with its output enable through a complete access. The access has three timed parts: address setup, strobe, and hold plus recovery. At the end it returns a one-cycle completion pulse and, for reads, the captured data.

Every bus interval is a nanosecond parameter. Each one is turned into whole clock periods by rounding up. The recovery phase is stretched when it has to be, so that setup, strobe and recovery together are never shorter than the minimum access cycle. Byte accesses use only the low lane: a byte write drives bits 15:8 as zero, and a byte read returns the low byte with bits 15:8 cleared. Word accesses, as used for the data register, carry all 16 bits.

The controller is a five-state machine:
- IDLE goes to SETUP when a request is accepted.
- SETUP goes to STROBE when the setup count expires.
- STROBE goes to HOLD when the pulse count expires. Read data is captured on this transition.
- HOLD goes to RECOVER when the hold count expires.
- RECOVER goes to IDLE when the recovery count expires, and the completion pulse is raised on this transition.

Top module: `ide_pio_ctrl`

## Requirements
- R1: While rst_n is low, both chip selects and both strobes are high, ide_dout_en is 0, ide_addr is 0, req_ready is 1, done is 0 and rdata is 0.
- R2: A request with req_ctl=0 drives ide_cs_n=2'b10 (task-file space). A request with req_ctl=1 drives ide_cs_n=2'b01 (control space). ide_addr carries req_reg from acceptance until the access ends, and at most one chip select is ever low.
- R3: After acceptance, chip select and address are driven for S=ceil(T_SETUP_NS/CLK_NS) cycles before the strobe falls.
- R4: The strobe stays low for P=ceil(T_PULSE_NS/CLK_NS) cycles. ide_rd_n is the strobe for reads and ide_wr_n is the strobe for writes, and the two are never low together.
- R5: Chip select, address and write data are held for H=ceil(T_HOLD_NS/CLK_NS) cycles after the strobe rises.
- R6: After the hold, both chip selects are high for R=max(1, ceil(T_RECOV_NS/CLK_NS)-H, ceil(T_CYCLE_NS/CLK_NS)-S-P-H) cycles. Strobe falls are therefore spaced by at least the cycle minimum, and strobe rise to the next fall is at least the recovery minimum.
- R7: ide_dout_en is 1 only during write accesses, from the first setup cycle through the last hold cycle. A byte write drives ide_dout[15:8]=0 and ide_dout[7:0]=req_wdata[7:0]. A word write drives all 16 bits.
- R8: A read captures ide_din in the last strobe cycle and presents it on rdata. A byte read gives {8'h00, ide_din[7:0]} and a word read gives ide_din.
- R9: req_ready is 1 only in IDLE. A request seen while busy is held off until ready returns, and its fields have no effect on the access in progress. done pulses for exactly one cycle, S+P+H+R cycles after acceptance.
- R10: ide_dout_en is never 1 during a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; kept high until accepted |
| req_ready | output | 1 | Sequencer idle; request taken this cycle if valid |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_ctl | input | 1 | 0 = task-file space, 1 = control space |
| req_reg | input | 3 | Register number within the space |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = low byte only |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data captured by the last read |
| ide_cs_n | output | 2 | Active-low selects: bit 0 task file, bit 1 control |
| ide_addr | output | 3 | Register address on the bus |
| ide_rd_n | output | 1 | Active-low read strobe |
| ide_wr_n | output | 1 | Active-low write strobe |
| ide_dout | output | 16 | Data driven toward the bus |
| ide_dout_en | output | 1 | Enable for the bus output driver |
| ide_din | input | 16 | Data received from the bus |

## Verification
The hardest situation to create from the ports is a second request that is already pending at the moment the completion pulse fires. In that case the acceptance cycle overlaps done, and the fields change while the earlier access is still running. The stimulus reaches this by issuing the next request as soon as the previous one is accepted, so req_valid sits high through a whole busy period with new fields. The behavioural bench model, stepped every cycle, then shows whether anything leaked into the running access and whether acceptance happens exactly in the done cycle. A device model stores data on each rising write strobe and returns it on reads, so byte-lane zeroing is seen end to end.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int PIO_DATA_W = 16;
    localparam int PIO_ADDR_W = 3;
    localparam int PIO_LANE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOVER
    } pio_state_t;

    typedef struct packed {
        logic                  write;
        logic                  ctl;
        logic [PIO_ADDR_W-1:0] reg_sel;
        logic                  wide;
        logic [PIO_DATA_W-1:0] wdata;
    } pio_req_t;

    function automatic int ns2cyc(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ide_pio_req_latch.sv
module ide_pio_req_latch
    import ide_pio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     take,
    input  pio_req_t req_d,
    output pio_req_t req_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (take) begin
            req_q <= req_d;
        end
    end

endmodule

// File: rtl/ide_pio_lane.sv
module ide_pio_lane #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] drive_word,
    output logic [DATA_W-1:0] read_word
);

    localparam int NLANES = DATA_W / LANE_W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign drive_word[LANE_W-1:0] = wdata[LANE_W-1:0];
            assign read_word[LANE_W-1:0]  = din[LANE_W-1:0];
        end else begin : g_high
            assign drive_word[g*LANE_W +: LANE_W] = wide ? wdata[g*LANE_W +: LANE_W] : '0;
            assign read_word[g*LANE_W +: LANE_W]  = wide ? din[g*LANE_W +: LANE_W]   : '0;
        end
    end

endmodule

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
    import ide_pio_pkg::*;
#(
    parameter int CLK_NS      = 5,
    parameter int T_SETUP_NS  = 25,
    parameter int T_PULSE_NS  = 70,
    parameter int T_HOLD_NS   = 10,
    parameter int T_RECOV_NS  = 25,
    parameter int T_CYCLE_NS  = 120
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_ctl,
    input  logic [PIO_ADDR_W-1:0] req_reg,
    input  logic                  req_wide,
    input  logic [PIO_DATA_W-1:0] req_wdata,
    output logic                  done,
    output logic [PIO_DATA_W-1:0] rdata,
    output logic [1:0]            ide_cs_n,
    output logic [PIO_ADDR_W-1:0] ide_addr,
    output logic                  ide_rd_n,
    output logic                  ide_wr_n,
    output logic [PIO_DATA_W-1:0] ide_dout,
    output logic                  ide_dout_en,
    input  logic [PIO_DATA_W-1:0] ide_din
);

    localparam int SETUP_CYC = ns2cyc(T_SETUP_NS, CLK_NS);
    localparam int PULSE_CYC = ns2cyc(T_PULSE_NS, CLK_NS);
    localparam int HOLD_CYC  = ns2cyc(T_HOLD_NS, CLK_NS);
    localparam int RECOV_CYC = ns2cyc(T_RECOV_NS, CLK_NS);
    localparam int CYCLE_CYC = ns2cyc(T_CYCLE_NS, CLK_NS);
    localparam int REST_CYC  = max3(1, RECOV_CYC - HOLD_CYC,
                                    CYCLE_CYC - SETUP_CYC - PULSE_CYC - HOLD_CYC);
    localparam int MAX_CYC   = max3(SETUP_CYC, PULSE_CYC, max3(HOLD_CYC, REST_CYC, 1));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REST  = CNT_W'(REST_CYC - 1);

    pio_state_t            state_q, state_d;
    pio_req_t              req_in, cur;
    logic                  accept;
    logic                  tmr_load;
    logic [CNT_W-1:0]      tmr_val;
    logic                  tmr_done;
    logic [PIO_DATA_W-1:0] drive_word;
    logic [PIO_DATA_W-1:0] read_word;
    logic                  done_q;
    logic [PIO_DATA_W-1:0] rdata_q;
    logic                  capture;

    assign req_in = '{write: req_write, ctl: req_ctl, reg_sel: req_reg,
                      wide: req_wide, wdata: req_wdata};
    assign accept = (state_q == ST_IDLE) && req_valid;

    ide_pio_req_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (accept),
        .req_d (req_in),
        .req_q (cur)
    );

    ide_pio_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    ide_pio_lane #(.DATA_W(PIO_DATA_W), .LANE_W(PIO_LANE_W)) u_lane (
        .wide       (cur.wide),
        .wdata      (cur.wdata),
        .din        (ide_din),
        .drive_word (drive_word),
        .read_word  (read_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_RECOVER) && tmr_done;
            if (capture) begin
                rdata_q <= read_word;
            end
        end
    end

    // next state and phase timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                    capture  = !cur.write;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = LD_REST;
                end
            end
            ST_RECOVER: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // bus outputs decoded from the state
    always_comb begin
        req_ready   = 1'b0;
        ide_cs_n    = 2'b11;
        ide_addr    = cur.reg_sel;
        ide_rd_n    = 1'b1;
        ide_wr_n    = 1'b1;
        ide_dout_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                ide_addr  = '0;
            end
            ST_SETUP, ST_HOLD: begin
                ide_cs_n    = cur.ctl ? 2'b01 : 2'b10;
                ide_dout_en = cur.write;
            end
            ST_STROBE: begin
                ide_cs_n    = cur.ctl ? 2'b01 : 2'b10;
                ide_dout_en = cur.write;
                ide_rd_n    = cur.write;
                ide_wr_n    = !cur.write;
            end
            ST_RECOVER: begin
                ide_cs_n = 2'b11;
            end
            default: req_ready = 1'b0;
        endcase
    end

    assign ide_dout = ide_dout_en ? drive_word : '0;
    assign done     = done_q;
    assign rdata    = rdata_q;

endmodule

// File: rtl/ide_pio_ctrl_chk.sv
module ide_pio_ctrl_chk #(
    parameter int PULSE_MIN = 1,
    parameter int CYCLE_MIN = 1,
    parameter int RECOV_MIN = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        done,
    input logic [1:0]  ide_cs_n,
    input logic [2:0]  ide_addr,
    input logic        ide_rd_n,
    input logic        ide_wr_n,
    input logic [15:0] ide_dout,
    input logic        ide_dout_en
);

    localparam logic [15:0] SAT = 16'hFFFF;

    logic        strobe_lo, strobe_lo_q;
    logic        rose_lo, fell_lo;
    logic [15:0] low_cnt, since_fall, since_rise;

    assign strobe_lo = !ide_rd_n || !ide_wr_n;
    assign rose_lo   = strobe_lo && !strobe_lo_q;
    assign fell_lo   = !strobe_lo && strobe_lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_lo_q <= 1'b0;
            low_cnt     <= '0;
            since_fall  <= SAT;
            since_rise  <= SAT;
        end else begin
            strobe_lo_q <= strobe_lo;
            low_cnt     <= strobe_lo ? ((low_cnt == SAT) ? SAT : low_cnt + 1'b1) : '0;
            since_fall  <= rose_lo ? 16'd1 : ((since_fall == SAT) ? SAT : since_fall + 1'b1);
            since_rise  <= fell_lo ? 16'd1 : ((since_rise == SAT) ? SAT : since_rise + 1'b1);
        end
    end

    assert_single_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ide_cs_n));

    assert_strobe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rose_lo |-> (ide_cs_n != 2'b11) && $stable(ide_cs_n) && $stable(ide_addr));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_rd_n && !ide_wr_n));

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fell_lo |-> low_cnt >= 16'(PULSE_MIN));

    assert_hold_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fell_lo |-> (ide_cs_n != 2'b11) && $stable(ide_cs_n) && $stable(ide_addr));

    assert_wdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ide_wr_n) |-> ide_dout_en && $stable(ide_dout));

    assert_cycle_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rose_lo |-> since_fall >= 16'(CYCLE_MIN));

    assert_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rose_lo |-> since_rise >= 16'(RECOV_MIN));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ide_cs_n == 2'b11) && !ide_dout_en);

    assert_no_drive_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_rd_n |-> !ide_dout_en);

endmodule

bind ide_pio_ctrl ide_pio_ctrl_chk #(
    .PULSE_MIN (PULSE_CYC),
    .CYCLE_MIN (CYCLE_CYC),
    .RECOV_MIN (RECOV_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .done        (done),
    .ide_cs_n    (ide_cs_n),
    .ide_addr    (ide_addr),
    .ide_rd_n    (ide_rd_n),
    .ide_wr_n    (ide_wr_n),
    .ide_dout    (ide_dout),
    .ide_dout_en (ide_dout_en)
);

// File: tb/ide_pio_ctrl_bench.sv
`timescale 1ns/1ps
module ide_pio_ctrl_bench;

    // bench-side timing, derived independently from the nanosecond minimums
    localparam int CLK_NS = 5;
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    localparam int S  = cdiv(25, CLK_NS);
    localparam int P  = cdiv(70, CLK_NS);
    localparam int H  = cdiv(10, CLK_NS);
    localparam int RC = cdiv(25, CLK_NS);
    localparam int CY = cdiv(120, CLK_NS);
    localparam int R_A = (RC - H > 1) ? RC - H : 1;
    localparam int R  = (CY - S - P - H > R_A) ? CY - S - P - H : R_A;
    localparam int TOTAL = S + P + H + R;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_ctl = 1'b0;
    logic [2:0]  req_reg = 3'd0;
    logic        req_wide = 1'b0;
    logic [15:0] req_wdata = 16'd0;
    logic        done;
    logic [15:0] rdata;
    logic [1:0]  ide_cs_n;
    logic [2:0]  ide_addr;
    logic        ide_rd_n;
    logic        ide_wr_n;
    logic [15:0] ide_dout;
    logic        ide_dout_en;
    logic [15:0] ide_din;

    always #2.5 clk = ~clk;

    ide_pio_ctrl u_ide_pio_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_ctl(req_ctl), .req_reg(req_reg), .req_wide(req_wide), .req_wdata(req_wdata),
        .done(done), .rdata(rdata),
        .ide_cs_n(ide_cs_n), .ide_addr(ide_addr), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
        .ide_dout(ide_dout), .ide_dout_en(ide_dout_en), .ide_din(ide_din)
    );

    // device model: 8 registers per space, index = {control space, address}
    logic [15:0] dev_mem [16];
    logic [15:0] ref_mem [16];
    logic [3:0]  dev_idx;
    assign dev_idx = {!ide_cs_n[1], ide_addr};
    assign ide_din = !ide_rd_n ? dev_mem[dev_idx] : 16'hBEEF;

    always @(posedge ide_wr_n) begin
        if (rst_n) dev_mem[dev_idx] <= ide_dout;
    end

    int vectors = 0;
    int fails = 0;
    int wd = 0;

    task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // behavioural reference model, stepped at every falling edge
    bit          m_busy = 0, m_done = 0, m_done_rd = 0;
    int          m_t = 0;
    bit          m_wr, m_ctl, m_wide;
    logic [2:0]  m_reg;
    logic [15:0] m_wd;
    logic [15:0] m_rdata = 16'd0;

    always @(negedge clk) begin
        int ph;
        logic [1:0]  e_cs;
        logic        e_oe;
        logic [3:0]  ix;
        string       tag;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_rdata = 16'd0;
            // R1 reset state
            chk("R1", "cs_n", {14'd0, ide_cs_n}, 16'd3);
            chk("R1", "strobes", {14'd0, ide_rd_n, ide_wr_n}, 16'd3);
            chk("R1", "dout_en", {15'd0, ide_dout_en}, 16'd0);
            chk("R1", "addr", {13'd0, ide_addr}, 16'd0);
            chk("R1", "ready/done", {14'd0, req_ready, done}, 16'd2);
            chk("R1", "rdata", rdata, 16'd0);
        end else begin
            ph = !m_busy ? 0 : (m_t < S) ? 1 : (m_t < S + P) ? 2 : (m_t < S + P + H) ? 3 : 4;
            tag = (ph == 1) ? "R3" : (ph == 2) ? "R2" : (ph == 3) ? "R5" : (ph == 4) ? "R6" : "R9";
            e_cs = (ph >= 1 && ph <= 3) ? (m_ctl ? 2'b01 : 2'b10) : 2'b11;
            chk(tag, "cs_n", {14'd0, ide_cs_n}, {14'd0, e_cs});
            chk("R2", "addr", {13'd0, ide_addr}, m_busy ? {13'd0, m_reg} : 16'd0);
            chk("R4", "rd_n", {15'd0, ide_rd_n}, {15'd0, !(ph == 2 && !m_wr)});
            chk("R4", "wr_n", {15'd0, ide_wr_n}, {15'd0, !(ph == 2 && m_wr)});
            e_oe = m_busy && m_wr && ph >= 1 && ph <= 3;
            chk(m_wr ? "R7" : "R10", "dout_en", {15'd0, ide_dout_en}, {15'd0, e_oe});
            chk("R7", "dout", ide_dout, e_oe ? (m_wide ? m_wd : {8'h00, m_wd[7:0]}) : 16'd0);
            chk("R9", "ready", {15'd0, req_ready}, {15'd0, !m_busy});
            chk("R9", "done", {15'd0, done}, {15'd0, m_done});
            if (m_done && m_done_rd) chk("R8", "rdata", rdata, m_rdata);

            // predict the next cycle
            m_done = 0;
            if (!m_busy && req_valid) begin
                m_busy = 1; m_t = 0;
                m_wr = req_write; m_ctl = req_ctl; m_reg = req_reg;
                m_wide = req_wide; m_wd = req_wdata;
            end else if (m_busy) begin
                m_t++;
                if (m_t == TOTAL) begin
                    m_busy = 0; m_done = 1; m_done_rd = !m_wr;
                    ix = {m_ctl, m_reg};
                    if (m_wr) ref_mem[ix] = m_wide ? m_wd : {8'h00, m_wd[7:0]};
                    else m_rdata = m_wide ? ref_mem[ix] : {8'h00, ref_mem[ix][7:0]};
                end
            end
        end
    end

    task automatic do_req(input bit wr, input bit ctl, input logic [2:0] rg, input bit wide, input logic [15:0] wd);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_ctl = ctl; req_reg = rg;
        req_wide = wide; req_wdata = wd;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        // scramble the fields: they must not reach the running access (R9)
        req_valid = 1'b0; req_write = !wr; req_ctl = !ctl; req_reg = ~rg;
        req_wide = !wide; req_wdata = ~wd;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!req_ready || done);
        repeat (3) @(posedge clk);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            dev_mem[i] = 16'h1000 + 16'(i) * 16'h0111 + 16'h8000;
            ref_mem[i] = dev_mem[i];
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        // R7 word write to the data register, R8 word read back
        do_req(1, 0, 3'd0, 1, 16'hA5C3);
        wait_idle();
        do_req(0, 0, 3'd0, 1, 16'h0000);
        wait_idle();
        // R7 byte write clears the upper lane; word read shows it
        do_req(1, 0, 3'd3, 0, 16'h12F0);
        wait_idle();
        do_req(0, 0, 3'd3, 1, 16'h0000);
        wait_idle();
        // R8 byte read from control space zero-extends
        do_req(0, 1, 3'd6, 0, 16'h0000);
        wait_idle();
        do_req(1, 1, 3'd6, 0, 16'hFF3C);
        wait_idle();
        // R9 back-to-back: each request waits through the previous access
        do_req(0, 1, 3'd6, 1, 16'h0000);
        do_req(1, 0, 3'd7, 1, 16'h5A5A);
        do_req(0, 0, 3'd7, 1, 16'h0000);
        do_req(0, 1, 3'd1, 0, 16'h0000);
        wait_idle();
        // sweep all registers in both spaces, alternating width
        for (int i = 0; i < 16; i++) begin
            do_req(0, i[3], i[2:0], i[0], 16'h0000);
        end
        wait_idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule